// File: doc/BRIEF.md
# GPIO Event Routing Controller

This block turns edges on general-purpose input pins into system event requests. Each pin has a sticky status bit. The bit sets when the pin, configured as an input, goes from low to high. Software clears it by writing a one. A route register gives each pin a two-bit field. The field sends a pending status to one of three outputs: the active-low system-management interrupt, the level-type system-control interrupt, or a non-maskable interrupt pulse. A route only fires when the pin's own enable bit for that destination is also set.

Wake requests are generated separately from routing. While the platform is in a sleep state (S1 to S5), a set status bit raises the wake request if the pin's system-control enable is set, whatever its route field holds. A parameter mask chooses which pins exist. Pins that are not implemented have no route field storage and no status bit.

Top module: `gpio_event_router`

## Requirements
- R1: After reset the route register reads zero, every status bit is 0, `smi_n` is 1, and `sci`, `nmi_pulse` and `wake` are 0.
- R2: A write to the route register stores pin n's field at bits 2n+1:2n, and the register reads it back one cycle later. Fields of pins absent from `IMPL_MASK` read 0 and ignore writes.
- R3: A status bit sets on the clock edge that sees its pin high while the pin was low on the previous edge, but only if the pin is configured as an input and implemented. Otherwise the bit stays 0.
- R4: Writing 1 to a status bit through the clear port clears it on the next edge. Bits written with 0 keep their value.
- R5: `smi_n` is low while any pin has status set, is an input, has route 01 and has its SMI enable set.
- R6: `sci` is high while any pin has status set, is an input, has route 10 and has its SCI enable set.
- R7: `nmi_pulse` is high for exactly one cycle when some pin first has status set, is an input, has route 11 and has its NMI enable set.
- R8: Route 00, a missing matching enable, or a non-input pin produces no SMI, SCI or NMI event.
- R9: `wake` is high while `sleep_state` is 1 and any pin has status set with its SCI enable set, for any route value. It is 0 while `sleep_state` is 0.
- R10: If a rising edge and a clear write hit the same status bit on the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Route register write strobe |
| reg_wdata | input | 2*N_GPIO | Route register write data |
| route_rd | output | 2*N_GPIO | Route register read value |
| sts_clr_wr | input | 1 | Status clear strobe |
| sts_clr_data | input | N_GPIO | Write-one-to-clear mask for status |
| status | output | N_GPIO | Sticky status bits |
| gpi_level | input | N_GPIO | Pin levels |
| gpi_is_input | input | N_GPIO | Pin is configured as an input |
| smi_en | input | N_GPIO | Per-pin SMI enable |
| sci_en | input | N_GPIO | Per-pin SCI enable, also used for wake |
| nmi_en | input | N_GPIO | Per-pin NMI enable |
| sleep_state | input | 1 | Platform is in S1 to S5 |
| smi_n | output | 1 | System-management interrupt, active low |
| sci | output | 1 | System-control interrupt level |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt |
| wake | output | 1 | Wake request |

## Verification
A route write shows on `route_rd` after one edge. A pin's rising level sets its status on the next edge. From the status register, `smi_n`, `sci` and `wake` follow combinationally, so they are due in the same cycle. `nmi_pulse` is high in that same cycle and low again after the following edge. The bench drives everything on the falling clock edge and samples one falling edge later for registered results, and 1 ns after a change for combinational ones such as `wake` when `sleep_state` toggles. The sweep covers every pin, every route code, every enable combination and both direction settings.

// File: rtl/gper_pkg.sv
package gper_pkg;
  typedef enum logic [1:0] {
    ROUTE_NONE = 2'b00,
    ROUTE_SMI  = 2'b01,
    ROUTE_SCI  = 2'b10,
    ROUTE_NMI  = 2'b11
  } route_e;

  // Expand a per-pin implemented mask into a two-bit-per-pin field mask.
  function automatic logic [31:0] field_mask16(input logic [15:0] impl);
    logic [31:0] m;
    for (int i = 0; i < 16; i++) begin
      m[2*i +: 2] = {2{impl[i]}};
    end
    return m;
  endfunction
endpackage

// File: rtl/gper_route_reg.sv
module gper_route_reg #(
  parameter int unsigned N_GPIO = 16,
  parameter logic [N_GPIO-1:0] IMPL_MASK = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [2*N_GPIO-1:0] wdata,
  output logic [2*N_GPIO-1:0] route_q
);
  for (genvar i = 0; i < N_GPIO; i++) begin : g_field
    if (IMPL_MASK[i]) begin : g_impl
      logic [1:0] fld;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     fld <= 2'b00;
        else if (wr_en) fld <= wdata[2*i +: 2];
      end
      assign route_q[2*i +: 2] = fld;
    end else begin : g_absent
      assign route_q[2*i +: 2] = 2'b00;
    end
  end
endmodule

// File: rtl/gper_status.sv
module gper_status #(
  parameter int unsigned N_GPIO = 16,
  parameter logic [N_GPIO-1:0] IMPL_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_GPIO-1:0] level,
  input  logic [N_GPIO-1:0] is_input,
  input  logic              clr_wr,
  input  logic [N_GPIO-1:0] clr_data,
  output logic [N_GPIO-1:0] sts_q
);
  logic [N_GPIO-1:0] level_q;
  logic [N_GPIO-1:0] rise;
  logic [N_GPIO-1:0] clr_mask;

  assign rise     = level & ~level_q & is_input & IMPL_MASK;
  assign clr_mask = clr_wr ? clr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      sts_q   <= '0;
    end else begin
      level_q <= level;
      // a new edge wins over a clear landing on the same cycle
      sts_q   <= ((sts_q & ~clr_mask) | rise) & IMPL_MASK;
    end
  end
endmodule

// File: rtl/gper_route_decode.sv
module gper_route_decode
  import gper_pkg::*;
#(
  parameter int unsigned N_GPIO = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*N_GPIO-1:0] route_q,
  input  logic [N_GPIO-1:0]   sts,
  input  logic [N_GPIO-1:0]   is_input,
  input  logic [N_GPIO-1:0]   smi_en,
  input  logic [N_GPIO-1:0]   sci_en,
  input  logic [N_GPIO-1:0]   nmi_en,
  input  logic                sleep_state,
  output logic                smi_n,
  output logic                sci,
  output logic                nmi_pulse,
  output logic                wake
);
  logic [N_GPIO-1:0] smi_hit, sci_hit, nmi_hit;
  logic nmi_any, nmi_q;

  for (genvar i = 0; i < N_GPIO; i++) begin : g_pin
    route_e rt;
    logic   live;
    assign rt         = route_e'(route_q[2*i +: 2]);
    assign live       = sts[i] & is_input[i];
    assign smi_hit[i] = live & (rt == ROUTE_SMI) & smi_en[i];
    assign sci_hit[i] = live & (rt == ROUTE_SCI) & sci_en[i];
    assign nmi_hit[i] = live & (rt == ROUTE_NMI) & nmi_en[i];
  end

  assign nmi_any = |nmi_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_q <= 1'b0;
    else        nmi_q <= nmi_any;
  end

  assign smi_n     = ~(|smi_hit);
  assign sci       = |sci_hit;
  assign nmi_pulse = nmi_any & ~nmi_q;
  assign wake      = sleep_state & (|(sts & sci_en));
endmodule

// File: rtl/gpio_event_router.sv
module gpio_event_router #(
  parameter int unsigned N_GPIO = 16,
  parameter logic [N_GPIO-1:0] IMPL_MASK = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic [2*N_GPIO-1:0] reg_wdata,
  output logic [2*N_GPIO-1:0] route_rd,
  input  logic                sts_clr_wr,
  input  logic [N_GPIO-1:0]   sts_clr_data,
  output logic [N_GPIO-1:0]   status,
  input  logic [N_GPIO-1:0]   gpi_level,
  input  logic [N_GPIO-1:0]   gpi_is_input,
  input  logic [N_GPIO-1:0]   smi_en,
  input  logic [N_GPIO-1:0]   sci_en,
  input  logic [N_GPIO-1:0]   nmi_en,
  input  logic                sleep_state,
  output logic                smi_n,
  output logic                sci,
  output logic                nmi_pulse,
  output logic                wake
);
  gper_route_reg #(.N_GPIO(N_GPIO), .IMPL_MASK(IMPL_MASK)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wdata(reg_wdata),
    .route_q(route_rd)
  );

  gper_status #(.N_GPIO(N_GPIO), .IMPL_MASK(IMPL_MASK)) u_sts (
    .clk(clk), .rst_n(rst_n), .level(gpi_level), .is_input(gpi_is_input),
    .clr_wr(sts_clr_wr), .clr_data(sts_clr_data), .sts_q(status)
  );

  gper_route_decode #(.N_GPIO(N_GPIO)) u_dec (
    .clk(clk), .rst_n(rst_n), .route_q(route_rd), .sts(status),
    .is_input(gpi_is_input), .smi_en(smi_en), .sci_en(sci_en),
    .nmi_en(nmi_en), .sleep_state(sleep_state), .smi_n(smi_n),
    .sci(sci), .nmi_pulse(nmi_pulse), .wake(wake)
  );
endmodule

// File: rtl/gper_checker.sv
module gper_checker #(
  parameter int unsigned N_GPIO = 16,
  parameter logic [N_GPIO-1:0] IMPL_MASK = '1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2*N_GPIO-1:0] route_rd,
  input logic [N_GPIO-1:0]   status,
  input logic [N_GPIO-1:0]   gpi_is_input,
  input logic [N_GPIO-1:0]   smi_en,
  input logic [N_GPIO-1:0]   sci_en,
  input logic [N_GPIO-1:0]   nmi_en,
  input logic                sleep_state,
  input logic                smi_n,
  input logic                sci,
  input logic                nmi_pulse,
  input logic                wake
);
  logic [2*N_GPIO-1:0] fmask;
  always_comb begin
    for (int i = 0; i < N_GPIO; i++) fmask[2*i +: 2] = {2{IMPL_MASK[i]}};
  end

  p_absent_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (route_rd & ~fmask) == '0);

  p_set_needs_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(gpi_is_input)) == '0));

  p_smi_qualified_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !smi_n |-> |(status & smi_en & gpi_is_input));

  p_sci_qualified_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sci |-> |(status & sci_en & gpi_is_input));

  p_nmi_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pulse |=> !nmi_pulse);

  p_nmi_qualified_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pulse |-> |(status & nmi_en & gpi_is_input));

  p_wake_awake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_state |-> !wake);
endmodule

bind gpio_event_router gper_checker #(.N_GPIO(N_GPIO), .IMPL_MASK(IMPL_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .route_rd(route_rd), .status(status),
  .gpi_is_input(gpi_is_input), .smi_en(smi_en), .sci_en(sci_en),
  .nmi_en(nmi_en), .sleep_state(sleep_state), .smi_n(smi_n), .sci(sci),
  .nmi_pulse(nmi_pulse), .wake(wake)
);

// File: tb/sim_gpio_event_router.sv
`timescale 1ns/1ps
module sim_gpio_event_router;
  localparam int N = 16;
  localparam logic [N-1:0] IMPL = 16'hEFFF; // GPIO12 absent

  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0, sts_clr_wr = 0, sleep_state = 0;
  logic [2*N-1:0] reg_wdata = '0, route_rd;
  logic [N-1:0] sts_clr_data = '0, status, gpi_level = '0, gpi_is_input = '0;
  logic [N-1:0] smi_en = '0, sci_en = '0, nmi_en = '0;
  logic smi_n, sci, nmi_pulse, wake;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_event_router #(.N_GPIO(N), .IMPL_MASK(IMPL)) u0 (.*);

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input int p, input int r, input int en, input int inp);
    logic st;
    logic smi_x, sci_x, nmi_x, wk_x;
    st    = inp[0] & IMPL[p];
    smi_x = st & (r == 1) & en[0];
    sci_x = st & (r == 2) & en[1];
    nmi_x = st & (r == 3) & en[2];
    wk_x  = st & en[1];
    @(negedge clk);
    reg_wr_en = 1; reg_wdata = 32'(r) << (2*p);
    smi_en = N'(en[0]) << p; sci_en = N'(en[1]) << p; nmi_en = N'(en[2]) << p;
    gpi_is_input = N'(inp) << p; gpi_level = '0; sleep_state = 0;
    @(negedge clk);
    reg_wr_en = 0; gpi_level[p] = 1'b1;
    @(negedge clk);
    chk(status, N'(st) << p, "R3 status set");
    chk(smi_n, !smi_x, smi_x ? "R5 smi" : "R8 smi idle");
    chk(sci, sci_x, sci_x ? "R6 sci" : "R8 sci idle");
    chk(nmi_pulse, nmi_x, nmi_x ? "R7 nmi pulse" : "R8 nmi idle");
    chk(wake, 0, "R9 wake awake");
    sleep_state = 1; #1;
    chk(wake, wk_x, "R9 wake asleep");
    @(negedge clk);
    chk(nmi_pulse, 0, "R7 nmi one cycle");
    chk(route_rd, IMPL[p] ? (32'(r) << (2*p)) : 32'h0, "R2 route readback");
    sts_clr_wr = 1; sts_clr_data = N'(1) << p; gpi_level = '0; sleep_state = 0;
    @(negedge clk);
    sts_clr_wr = 0; sts_clr_data = '0;
    chk(status, '0, "R4 cleared");
    chk({smi_n, sci}, 2'b10, "R8 idle after clear");
  endtask

  initial begin
    #50000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({route_rd, status, smi_n, sci, nmi_pulse, wake}, {32'h0, 16'h0, 4'b1000}, "R1 reset state");
    rst_n = 1;
    @(negedge clk);
    chk({route_rd, status, smi_n, sci, nmi_pulse, wake}, {32'h0, 16'h0, 4'b1000}, "R1 after release");
    // R2: full write shows implemented fields only
    reg_wr_en = 1; reg_wdata = '1;
    @(negedge clk); reg_wr_en = 0;
    chk(route_rd, 32'hFCFF_FFFF, "R2 absent field reads zero");
    reg_wr_en = 1; reg_wdata = 32'h1B1B_1B1B;
    @(negedge clk); reg_wr_en = 0;
    chk(route_rd, 32'h181B_1B1B, "R2 pattern");
    // R4: clear of one bit leaves the other
    gpi_is_input = 16'h0003; gpi_level = 16'h0003;
    @(negedge clk);
    chk(status, 16'h0003, "R3 two pins set");
    sts_clr_wr = 1; sts_clr_data = 16'h0001;
    @(negedge clk); sts_clr_wr = 0;
    chk(status, 16'h0002, "R4 selective clear");
    // R10: edge and clear on the same edge
    gpi_level = 16'h0000;
    @(negedge clk);
    gpi_level = 16'h0001; sts_clr_wr = 1; sts_clr_data = 16'h0003;
    @(negedge clk); sts_clr_wr = 0;
    chk(status, 16'h0001, "R10 set beats clear");
    sts_clr_wr = 1; sts_clr_data = '1; gpi_level = '0;
    @(negedge clk); sts_clr_wr = 0;
    chk(status, 16'h0000, "R4 clear all");
    // sweep: every pin, route code, enable combination and direction
    for (int p = 0; p < N; p++)
      for (int r = 0; r < 4; r++)
        for (int en = 0; en < 8; en++)
          for (int inp = 0; inp < 2; inp++)
            run(p, r, en, inp);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule